// File: doc/BRIEF.md
# Windowed Peak-to-Peak Trigger Detector

This block watches a stream of unsigned samples and, over consecutive non-overlapping windows, measures the spread between the largest and the smallest sample. Each window spans three quarters of one period of a tone picked by a 2-bit frequency select. The selectable tones are 25, 30, 35 and 40 kHz. At the end of every window the spread is compared against a programmed threshold. When automatic triggering is enabled and the spread is at least the threshold, a one-cycle trigger pulse goes out.

Alongside the trigger, the block keeps the largest spread seen since it was last cleared, so that software can read a signal-level figure for gain setting or its own detection. Two inputs clear that held figure: a software clear strobe, and the strobe that starts a new capture. A trigger by itself leaves the held figure untouched.

Top module: `ptp_trigger_detector`

## Requirements
- R1: After reset the held peak-to-peak output is 0 and the trigger output is low.
- R2: With the default 10 MHz sample rate, a window spans 300, 250, 214 or 188 accepted samples for frequency select values 0, 1, 2 or 3. These are 3/4 of a 25, 30, 35 or 40 kHz period, rounded to the nearest sample.
- R3: A window's measurement is the unsigned maximum minus the minimum of the samples accepted in it. A sample is accepted only in a cycle where the valid input is high, and data in cycles with valid low has no effect.
- R4: Windows tumble. The first accepted sample after a window ends seeds both extremes, so nothing from an earlier window enters a later measurement.
- R5: The held output is the largest measurement since the last clear. It takes a new value on the same clock edge that accepts a window's final sample.
- R6: A software clear strobe sets the held output to 0 on the next edge. This takes priority over a measurement that completes on that same edge.
- R7: A capture-start strobe also sets the held output to 0 on the next edge. A trigger pulse leaves the held output unchanged.
- R8: The trigger output is high for exactly one cycle, starting on the edge that accepts a window's final sample, when auto-trigger is enabled and the measurement is greater than or equal to the threshold. Equality fires.
- R9: No trigger pulse is produced when auto-trigger is disabled or when the measurement is below the threshold. The held output still updates in both cases.
- R10: In a cycle where the frequency select differs from its value in the previous cycle, the window in progress is discarded and any sample presented in that cycle is dropped. The next accepted sample starts a fresh window with the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample on smp_data is present this cycle |
| smp_data | input | SMP_W (10) | Unsigned sample |
| freq_sel | input | SEL_W (2) | Tone select: 0=25 kHz, 1=30 kHz, 2=35 kHz, 3=40 kHz |
| ptp_thresh | input | SMP_W (10) | Auto-trigger threshold |
| auto_trig_en | input | 1 | Enables the trigger pulse |
| ptp_clear | input | 1 | Software clear of the held value |
| capture_start | input | 1 | New-capture strobe, also clears the held value |
| ptp_held | output | SMP_W (10) | Largest measurement since the last clear |
| trig_pulse | output | 1 | One-cycle auto-trigger pulse |

## Verification
The hardest situation to reach from the ports is a frequency select change in the middle of a window. If the restart were missing, the change would not show at once: it would only move where a later window ends and what that window contains. The stimulus builds part of a window around a large spike and switches the select in a cycle that also carries a valid extreme sample. It then feeds exactly the new window length of quiet samples. The bench checks that no trigger comes early and that the pulse and held value reflect only the quiet data. Every window also has its extreme sample placed last and contains invalid cycles carrying full-scale or zero data. An off-by-one window length or an accepted invalid sample therefore changes the outcome.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

   // Window length in samples: 3/4 of one period of the selected tone,
   // rounded to the nearest sample. Tone frequency = base + idx * step.
   function automatic int unsigned win_len(
      input int unsigned sample_hz,
      input int unsigned base_hz,
      input int unsigned step_hz,
      input int unsigned idx
   );
      longint unsigned tone;
      longint unsigned num;
      tone = longint'(base_hz) + longint'(idx) * longint'(step_hz);
      num  = 3 * longint'(sample_hz) + 2 * tone;
      return int'(num / (4 * tone));
   endfunction

endpackage

// File: rtl/ptp_len_table.sv
module ptp_len_table #(
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned SAMPLE_HZ = 10_000_000,
   parameter int unsigned BASE_HZ   = 25_000,
   parameter int unsigned STEP_HZ   = 5_000,
   parameter int unsigned CNT_W     = 9
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] len_m1
);
   localparam int unsigned NUM_SEL = 1 << SEL_W;

   logic [CNT_W-1:0] tbl [NUM_SEL];

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_entry
      localparam int unsigned LEN = ptp_pkg::win_len(SAMPLE_HZ, BASE_HZ, STEP_HZ, i);
      if (LEN < 2) begin : g_short
         $error("ptp_len_table: window entry shorter than two samples");
      end
      if (LEN > (1 << CNT_W)) begin : g_long
         $error("ptp_len_table: window entry exceeds counter range");
      end
      assign tbl[i] = CNT_W'(LEN - 1);
   end

   assign len_m1 = tbl[sel];
endmodule

// File: rtl/ptp_window.sv
module ptp_window #(
   parameter int unsigned SMP_W     = 10,
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned SAMPLE_HZ = 10_000_000,
   parameter int unsigned BASE_HZ   = 25_000,
   parameter int unsigned STEP_HZ   = 5_000,
   parameter int unsigned CNT_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic [SEL_W-1:0] freq_sel,
   output logic             win_done,
   output logic [SMP_W-1:0] win_meas
);
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] len_m1;
   logic [SMP_W-1:0] run_max;
   logic [SMP_W-1:0] run_min;
   logic [SMP_W-1:0] cur_max;
   logic [SMP_W-1:0] cur_min;
   logic             restart;
   logic             take;
   logic             first;
   logic             last;

   ptp_len_table #(
      .SEL_W     (SEL_W),
      .SAMPLE_HZ (SAMPLE_HZ),
      .BASE_HZ   (BASE_HZ),
      .STEP_HZ   (STEP_HZ),
      .CNT_W     (CNT_W)
   ) u_len (
      .sel    (sel_q),
      .len_m1 (len_m1)
   );

   always_comb begin
      restart = (freq_sel != sel_q);
      take    = smp_valid && !restart;
      first   = (cnt == '0);
      last    = (cnt == len_m1);
      if (first) begin
         cur_max = smp_data;
         cur_min = smp_data;
      end else begin
         cur_max = (smp_data > run_max) ? smp_data : run_max;
         cur_min = (smp_data < run_min) ? smp_data : run_min;
      end
      win_done = take && last;
      win_meas = cur_max - cur_min;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= '0;
         cnt     <= '0;
         run_max <= '0;
         run_min <= '0;
      end else begin
         sel_q <= freq_sel;
         if (restart) begin
            cnt <= '0;
         end else if (take) begin
            cnt     <= last ? '0 : cnt + CNT_W'(1);
            run_max <= cur_max;
            run_min <= cur_min;
         end
      end
   end
endmodule

// File: rtl/ptp_peak_hold.sv
module ptp_peak_hold #(
   parameter int unsigned SMP_W          = 10,
   parameter bit          CLEAR_PRIORITY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  logic [SMP_W-1:0] val,
   output logic [SMP_W-1:0] held
);
   logic bigger;
   assign bigger = upd && (val > held);

   if (CLEAR_PRIORITY) begin : g_clr_first
      always_ff @(posedge clk) begin
         if (!rst_n)      held <= '0;
         else if (clr)    held <= '0;
         else if (bigger) held <= val;
      end
   end else begin : g_upd_first
      always_ff @(posedge clk) begin
         if (!rst_n)      held <= '0;
         else if (bigger) held <= val;
         else if (clr)    held <= '0;
      end
   end
endmodule

// File: rtl/ptp_trig_gen.sv
module ptp_trig_gen #(
   parameter int unsigned SMP_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_done,
   input  logic [SMP_W-1:0] win_meas,
   input  logic [SMP_W-1:0] thresh,
   input  logic             auto_en,
   output logic             trig
);
   logic hit;
   assign hit = win_done && auto_en && (win_meas >= thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) trig <= 1'b0;
      else        trig <= hit;
   end
endmodule

// File: rtl/ptp_trigger_detector.sv
module ptp_trigger_detector #(
   parameter int unsigned SMP_W          = 10,
   parameter int unsigned SEL_W          = 2,
   parameter int unsigned SAMPLE_HZ      = 10_000_000,
   parameter int unsigned BASE_HZ        = 25_000,
   parameter int unsigned STEP_HZ        = 5_000,
   parameter bit          CLEAR_PRIORITY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic [SEL_W-1:0] freq_sel,
   input  logic [SMP_W-1:0] ptp_thresh,
   input  logic             auto_trig_en,
   input  logic             ptp_clear,
   input  logic             capture_start,
   output logic [SMP_W-1:0] ptp_held,
   output logic             trig_pulse
);
   // The lowest tone gives the longest window, which sizes the counter.
   localparam int unsigned MAX_LEN = ptp_pkg::win_len(SAMPLE_HZ, BASE_HZ, STEP_HZ, 0);
   localparam int unsigned CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

   if (SMP_W < 2 || SMP_W > 16) begin : g_bad_smp_w
      $error("ptp_trigger_detector: SMP_W out of range 2..16");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel_w
      $error("ptp_trigger_detector: SEL_W out of range 1..4");
   end
   if (BASE_HZ == 0 || SAMPLE_HZ < 4 * BASE_HZ) begin : g_bad_rate
      $error("ptp_trigger_detector: sample rate too low for base tone");
   end

   logic             win_done;
   logic [SMP_W-1:0] win_meas;
   logic             hold_clr;

   assign hold_clr = ptp_clear || capture_start;

   ptp_window #(
      .SMP_W     (SMP_W),
      .SEL_W     (SEL_W),
      .SAMPLE_HZ (SAMPLE_HZ),
      .BASE_HZ   (BASE_HZ),
      .STEP_HZ   (STEP_HZ),
      .CNT_W     (CNT_W)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .freq_sel  (freq_sel),
      .win_done  (win_done),
      .win_meas  (win_meas)
   );

   ptp_peak_hold #(
      .SMP_W          (SMP_W),
      .CLEAR_PRIORITY (CLEAR_PRIORITY)
   ) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hold_clr),
      .upd   (win_done),
      .val   (win_meas),
      .held  (ptp_held)
   );

   ptp_trig_gen #(
      .SMP_W (SMP_W)
   ) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_done (win_done),
      .win_meas (win_meas),
      .thresh   (ptp_thresh),
      .auto_en  (auto_trig_en),
      .trig     (trig_pulse)
   );
endmodule

// File: rtl/ptp_trigger_checker.sv
module ptp_trigger_checker #(
   parameter int unsigned SMP_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic [SMP_W-1:0] ptp_thresh,
   input logic             auto_trig_en,
   input logic             ptp_clear,
   input logic             capture_start,
   input logic [SMP_W-1:0] ptp_held,
   input logic             trig_pulse
);
   AST_TRIG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |=> !trig_pulse);                                                 // R8

   AST_TRIG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> $past(auto_trig_en));                                         // R9

   AST_TRIG_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> $past(smp_valid));                                            // R3

   AST_TRIG_MEETS_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_pulse && !$past(ptp_clear) && !$past(capture_start))
         |-> (ptp_held >= $past(ptp_thresh)));                                     // R8

   AST_HELD_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ptp_clear) && !$past(capture_start)) |-> (ptp_held >= $past(ptp_held))); // R5

   AST_SW_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ptp_clear) |-> (ptp_held == '0));                                      // R6

   AST_START_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(capture_start) |-> (ptp_held == '0));                                  // R7
endmodule

bind ptp_trigger_detector ptp_trigger_checker #(.SMP_W(SMP_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .smp_valid     (smp_valid),
   .ptp_thresh    (ptp_thresh),
   .auto_trig_en  (auto_trig_en),
   .ptp_clear     (ptp_clear),
   .capture_start (capture_start),
   .ptp_held      (ptp_held),
   .trig_pulse    (trig_pulse)
);

// File: tb/tb_ptp_trigger_detector.sv
module tb_ptp_trigger_detector;
   localparam int SMP_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             smp_valid = 1'b0;
   logic [SMP_W-1:0] smp_data = '0;
   logic [1:0]       freq_sel = 2'd0;
   logic [SMP_W-1:0] ptp_thresh = '0;
   logic             auto_trig_en = 1'b0;
   logic             ptp_clear = 1'b0;
   logic             capture_start = 1'b0;
   logic [SMP_W-1:0] ptp_held;
   logic             trig_pulse;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   ptp_trigger_detector dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_valid     (smp_valid),
      .smp_data      (smp_data),
      .freq_sel      (freq_sel),
      .ptp_thresh    (ptp_thresh),
      .auto_trig_en  (auto_trig_en),
      .ptp_clear     (ptp_clear),
      .capture_start (capture_start),
      .ptp_held      (ptp_held),
      .trig_pulse    (trig_pulse)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One accepted sample; outputs are observed 1 ns after the edge.
   task automatic push(input int d);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = SMP_W'(d);
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
   endtask

   // Cycle with valid low and junk data on the bus.
   task automatic idle(input int junk);
      @(negedge clk);
      smp_valid = 1'b0;
      smp_data  = SMP_W'(junk);
      @(posedge clk);
      #1;
   endtask

   // Feeds len-1 samples (lo at index 3, mid elsewhere, invalid junk cycles
   // in between), checks no early trigger, then the final hi sample.
   task automatic run_window(input string req, input int len, input int mid,
                             input int lo, input int hi, input int exp_trig,
                             input int exp_held);
      bit early = 1'b0;
      for (int i = 0; i < len - 1; i++) begin
         if (i % 64 == 10) begin
            idle(1023);
            idle(0);
         end
         push(i == 3 ? lo : mid);
         if (trig_pulse) early = 1'b1;
      end
      check({req, " no trigger before last sample"}, int'(early), 0);
      push(hi);
      check({req, " trigger at window end"}, int'(trig_pulse), exp_trig);
      check({req, " held value"}, int'(ptp_held), exp_held);
      idle(1023);
      check({req, " trigger one cycle"}, int'(trig_pulse), 0);
   endtask

   task automatic set_sel(input int s);
      @(negedge clk);
      freq_sel = 2'(s);
      idle(0);
   endtask

   task automatic pulse_clear(input bit sw);
      @(negedge clk);
      if (sw) ptp_clear = 1'b1;
      else    capture_start = 1'b1;
      @(posedge clk);
      #1;
      ptp_clear = 1'b0;
      capture_start = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 held after reset", int'(ptp_held), 0);
      check("R1 trigger after reset", int'(trig_pulse), 0);
   endtask

   task automatic t_lengths;
      auto_trig_en = 1'b1;
      ptp_thresh   = 10'd100;
      set_sel(0);
      run_window("R2 R3 R8 sel0 len300", 300, 500, 450, 700, 1, 250);
      set_sel(1);
      run_window("R2 R5 sel1 len250", 250, 500, 480, 640, 1, 250);
      set_sel(2);
      run_window("R2 R5 sel2 len214", 214, 500, 300, 620, 1, 320);
      ptp_thresh = 10'd5;
      set_sel(3);
      run_window("R2 sel3 len188", 188, 500, 500, 510, 1, 320);
      check("R7 trigger leaves held intact", int'(ptp_held), 320);
   endtask

   task automatic t_tumble;
      ptp_thresh = 10'd60;
      pulse_clear(1'b1);
      run_window("R4 wide window", 188, 500, 100, 900, 1, 800);
      run_window("R4 reseeded narrow window", 188, 520, 500, 550, 0, 800);
   endtask

   task automatic t_thresh;
      pulse_clear(1'b1);
      check("R6 software clear", int'(ptp_held), 0);
      ptp_thresh = 10'd60;
      run_window("R8 equal fires", 188, 520, 500, 560, 1, 60);
      ptp_thresh = 10'd61;
      run_window("R9 below threshold", 188, 520, 500, 560, 0, 60);
      ptp_thresh = 10'd10;
      auto_trig_en = 1'b0;
      run_window("R9 disabled", 188, 500, 400, 600, 0, 200);
      auto_trig_en = 1'b1;
   endtask

   task automatic t_clears;
      pulse_clear(1'b0);
      check("R7 capture start clears", int'(ptp_held), 0);
      ptp_thresh = 10'd60;
      for (int i = 0; i < 187; i++) push(i == 3 ? 500 : 520);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 10'd570;
      ptp_clear = 1'b1;
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
      ptp_clear = 1'b0;
      check("R6 clear wins over update", int'(ptp_held), 0);
      check("R6 trigger still fires", int'(trig_pulse), 1);
   endtask

   task automatic t_freq_change;
      bit early = 1'b0;
      pulse_clear(1'b1);
      ptp_thresh = 10'd20;
      set_sel(2);
      for (int i = 0; i < 100; i++) push(i == 10 ? 1000 : 500);
      @(negedge clk);
      freq_sel  = 2'd3;
      smp_valid = 1'b1;
      smp_data  = 10'd0;
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
      for (int i = 0; i < 187; i++) begin
         push(i == 3 ? 485 : 500);
         if (trig_pulse) early = 1'b1;
      end
      check("R10 no trigger from discarded window", int'(early), 0);
      check("R10 held before fresh window ends", int'(ptp_held), 0);
      push(515);
      check("R10 trigger after new length", int'(trig_pulse), 1);
      check("R10 held reflects fresh window only", int'(ptp_held), 30);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      idle(0);
      t_reset();
      t_lengths();
      t_tumble();
      t_thresh();
      t_clears();
      t_freq_change();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule